// File: doc/BRIEF.md
# Control register access gate

This block sits beside the system-register access path and owns two system control registers that share one encoding pattern and differ only in the op1 field. One register belongs to the hypervisor level and is 64 bits wide. The other belongs to the kernel level, and the hypervisor can also reach it through redirection. Each request carries a privilege level (0 = user, 1 = kernel, 2 = hypervisor, 3 = monitor), the register encoding, a read/write flag and write data. The block also samples a set of control inputs:
- the nested-virtualisation bits;
- the virtual-memory read and write trap bits;
- the fine-grained trap bits and their qualifiers;
- the host-mode flag.

For every request it chooses one outcome: UNDEFINED, a trap to the hypervisor with a class code and a cause, a redirect to a fixed shadow-memory offset, or a real read or write of one of the two registers. The memory access for a redirect is made elsewhere. The meaning of the individual control bits is outside this block.

The response appears on registered outputs one clock cycle after the request. Reserved bits in each register are forced to their fixed values both at reset and on every write. The register pair is built from one parameterised cell.

Top module: `ctlgate_top`

## Requirements
- R1: After a synchronous reset, each register holds its reset parameter with the fixed bits applied (fixed-0 bits cleared, fixed-1 bits set). While reset is held and until the first request, the response kind is 0.
- R2: A request at level 0 to either encoding responds with kind 2 (undefined), and no register changes.
- R3: A level-1 request to the hypervisor encoding (op0=3, op1=4, CRn=1, CRm=0, op2=0) responds with kind 3 (trap), cause 1 (nested) and class 0x18 when nested bit 0 is set. Otherwise it responds with kind 2.
- R4: A level-1 read of the kernel encoding (op1=0, all other fields as in R3) traps with cause 2 (vm) when the hypervisor-enabled input and the vm read-trap bit are both set. A write does the same under the vm write-trap bit. The bit for the other direction has no effect, and a trapped write leaves the register unchanged.
- R5: A level-1 kernel-encoding access that passes R4 traps with cause 3 (fine-grained) when three conditions hold: the fine-grained trap bit for its direction is set, the feature-present input is set, and either the monitor level is absent or its enable input is set.
- R6: The level-1 checks are applied in a fixed order: the vm trap first, then the fine-grained trap, then the nested redirect. The reported cause is that of the first check that hits.
- R7: When all nested bits are 1 and no trap hits, a level-1 kernel-encoding access responds with kind 4 (redirect) and offset 0x110. Neither register is written.
- R8: At level 2, the hypervisor encoding accesses the hypervisor register (target 1). The kernel encoding accesses the hypervisor register when host mode is set, and the kernel register (target 0) when it is clear.
- R9: At level 3, each encoding accesses its own register directly with kind 1 (access), whatever the control inputs are.
- R10: A register write stores the write data with the fixed-0 bits cleared and the fixed-1 bits set.
- R11: A request whose encoding matches neither register, and any cycle without a valid request, responds with kind 0, class 0, offset 0 and read data 0, and changes no register.
- R12: A response appears one cycle after its request. Read data is the register value before any write in that same cycle, and a write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_lvl | input | 2 | Privilege level of the requester |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 (selects register) |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| nest_bits | input | NV_W | Nested-virtualisation bits, bit 0 lowest |
| hyp_enabled | input | 1 | Hypervisor level enabled in current state |
| vm_trap_rd | input | 1 | Virtual-memory read trap bit |
| vm_trap_wr | input | 1 | Virtual-memory write trap bit |
| fg_trap_rd | input | 1 | Fine-grained read trap bit |
| fg_trap_wr | input | 1 | Fine-grained write trap bit |
| fg_present | input | 1 | Fine-grained trap feature implemented |
| mon_present | input | 1 | Monitor level implemented |
| mon_fg_en | input | 1 | Monitor-level enable for fine-grained traps |
| host_mode | input | 1 | Host mode flag |
| rsp_kind | output | 3 | 0 none, 1 access, 2 undefined, 3 trap, 4 redirect |
| rsp_cause | output | 2 | Trap cause: 0 none, 1 nested, 2 vm, 3 fine-grained |
| rsp_class | output | CLS_W | Trap class code, 0 unless trapping |
| rsp_offset | output | OFF_W | Shadow offset, 0 unless redirecting |
| rsp_target | output | 1 | Register accessed: 1 hypervisor, 0 kernel |
| rsp_rdata | output | DATA_W | Read data on access reads, else 0 |

## Verification
The bench drives each level-1 trap source alone and then in combination, because a design with the wrong check order would report the cause of a later check. A design that keys the vm trap on the wrong direction would trap reads when only the write bit is set, and the bench catches this by reading the register back after each trapped write. Host-mode routing at level 2 is checked through monitor-level read-back of both registers, so a wrong target shows up as corrupted data in the other register. The bench also targets reserved-bit forcing with all-ones and all-zero writes, and unmatched encodings that must leave both registers untouched.

// File: rtl/ctlgate_pkg.sv
package ctlgate_pkg;

  typedef enum logic [2:0] {
    RSP_NONE   = 3'd0,
    RSP_ACCESS = 3'd1,
    RSP_UNDEF  = 3'd2,
    RSP_TRAP   = 3'd3,
    RSP_REDIR  = 3'd4
  } rsp_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_NEST = 2'd1,
    CAUSE_VM   = 2'd2,
    CAUSE_FG   = 2'd3
  } cause_e;

  localparam logic [1:0] LVL_USER = 2'd0;
  localparam logic [1:0] LVL_KERN = 2'd1;
  localparam logic [1:0] LVL_HYP  = 2'd2;
  localparam logic [1:0] LVL_MON  = 2'd3;

  localparam logic TGT_KERN = 1'b0;
  localparam logic TGT_HYP  = 1'b1;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysenc_t;

endpackage

// File: rtl/ctlgate_decode.sv
module ctlgate_decode #(
  parameter logic [1:0] OP0_VAL  = 2'b11,
  parameter logic [2:0] OP1_HYP  = 3'b100,
  parameter logic [2:0] OP1_KERN = 3'b000,
  parameter logic [3:0] CRN_VAL  = 4'b0001,
  parameter logic [3:0] CRM_VAL  = 4'b0000,
  parameter logic [2:0] OP2_VAL  = 3'b000
) (
  input  ctlgate_pkg::sysenc_t enc,
  output logic                 hit_hyp,
  output logic                 hit_kern
);
  logic common_ok;

  always_comb begin
    common_ok = (enc.op0 == OP0_VAL) && (enc.crn == CRN_VAL) &&
                (enc.crm == CRM_VAL) && (enc.op2 == OP2_VAL);
    hit_hyp   = common_ok && (enc.op1 == OP1_HYP);
    hit_kern  = common_ok && (enc.op1 == OP1_KERN);
  end
endmodule

// File: rtl/ctlgate_route.sv
module ctlgate_route #(
  parameter int NV_W = 3
) (
  input  logic                   valid,
  input  logic [1:0]             lvl,
  input  logic                   wr,
  input  logic                   hit_hyp,
  input  logic                   hit_kern,
  input  logic [NV_W-1:0]        nest_bits,
  input  logic                   hyp_enabled,
  input  logic                   vm_trap_rd,
  input  logic                   vm_trap_wr,
  input  logic                   fg_trap_rd,
  input  logic                   fg_trap_wr,
  input  logic                   fg_present,
  input  logic                   mon_present,
  input  logic                   mon_fg_en,
  input  logic                   host_mode,
  output ctlgate_pkg::rsp_kind_e kind,
  output ctlgate_pkg::cause_e    cause,
  output logic                   tgt
);
  import ctlgate_pkg::*;

  logic vm_hit;
  logic fg_hit;
  logic nest_all;

  always_comb begin
    vm_hit   = hyp_enabled && (wr ? vm_trap_wr : vm_trap_rd);
    fg_hit   = fg_present && (!mon_present || mon_fg_en) &&
               (wr ? fg_trap_wr : fg_trap_rd);
    nest_all = &nest_bits;
  end

  always_comb begin
    kind  = RSP_NONE;
    cause = CAUSE_NONE;
    tgt   = TGT_KERN;
    if (valid && (hit_hyp || hit_kern)) begin
      unique case (lvl)
        LVL_USER: kind = RSP_UNDEF;
        LVL_KERN: begin
          if (hit_hyp) begin
            if (nest_bits[0]) begin
              kind  = RSP_TRAP;
              cause = CAUSE_NEST;
            end else begin
              kind = RSP_UNDEF;
            end
          end else if (vm_hit) begin
            kind  = RSP_TRAP;
            cause = CAUSE_VM;
          end else if (fg_hit) begin
            kind  = RSP_TRAP;
            cause = CAUSE_FG;
          end else if (nest_all) begin
            kind = RSP_REDIR;
          end else begin
            kind = RSP_ACCESS;
            tgt  = TGT_KERN;
          end
        end
        LVL_HYP: begin
          kind = RSP_ACCESS;
          tgt  = (hit_hyp || host_mode) ? TGT_HYP : TGT_KERN;
        end
        default: begin
          kind = RSP_ACCESS;
          tgt  = hit_hyp ? TGT_HYP : TGT_KERN;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctlgate_cell.sv
module ctlgate_cell #(
  parameter int              W    = 64,
  parameter logic [W-1:0]    RST  = '0,
  parameter logic [W-1:0]    RES0 = '0,
  parameter logic [W-1:0]    RES1 = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] FIXED   = RES0 | RES1;
  localparam logic [W-1:0] RST_EFF = (RST & ~FIXED) | RES1;

  logic [W-1:0] wfix;

  always_comb wfix = (wdata & ~FIXED) | RES1;

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_EFF;
    else if (we) q <= wfix;
  end
endmodule

// File: rtl/ctlgate_top.sv
module ctlgate_top #(
  parameter int                 DATA_W     = 64,
  parameter int                 CLS_W      = 6,
  parameter int                 OFF_W      = 12,
  parameter int                 NV_W       = 3,
  parameter logic [CLS_W-1:0]   TRAP_CLASS = 6'h18,
  parameter logic [OFF_W-1:0]   SHADOW_OFF = 12'h110,
  parameter logic [2:0]         OP1_HYP    = 3'b100,
  parameter logic [2:0]         OP1_KERN   = 3'b000,
  parameter logic [DATA_W-1:0]  HYP_RST    = 64'h0000_0000_0000_0001,
  parameter logic [DATA_W-1:0]  HYP_RES0   = 64'hFF00_0000_0000_0000,
  parameter logic [DATA_W-1:0]  HYP_RES1   = 64'h0000_0000_30C5_0830,
  parameter logic [DATA_W-1:0]  KERN_RST   = 64'hFFFF_0000_0000_0000,
  parameter logic [DATA_W-1:0]  KERN_RES0  = 64'hF000_0000_0000_0000,
  parameter logic [DATA_W-1:0]  KERN_RES1  = 64'h0000_0000_0080_0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_lvl,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NV_W-1:0]   nest_bits,
  input  logic              hyp_enabled,
  input  logic              vm_trap_rd,
  input  logic              vm_trap_wr,
  input  logic              fg_trap_rd,
  input  logic              fg_trap_wr,
  input  logic              fg_present,
  input  logic              mon_present,
  input  logic              mon_fg_en,
  input  logic              host_mode,
  output logic [2:0]        rsp_kind,
  output logic [1:0]        rsp_cause,
  output logic [CLS_W-1:0]  rsp_class,
  output logic [OFF_W-1:0]  rsp_offset,
  output logic              rsp_target,
  output logic [DATA_W-1:0] rsp_rdata
);
  import ctlgate_pkg::*;

  localparam int NREG = 2;
  localparam logic [NREG-1:0][DATA_W-1:0] RSTS  = {HYP_RST,  KERN_RST};
  localparam logic [NREG-1:0][DATA_W-1:0] RES0S = {HYP_RES0, KERN_RES0};
  localparam logic [NREG-1:0][DATA_W-1:0] RES1S = {HYP_RES1, KERN_RES1};

  sysenc_t    enc;
  logic       hit_hyp, hit_kern;
  rsp_kind_e  kind;
  cause_e     cause;
  logic       tgt;
  logic [NREG-1:0]              we;
  logic [NREG-1:0][DATA_W-1:0]  q;

  always_comb begin
    enc.op0 = req_op0;
    enc.op1 = req_op1;
    enc.crn = req_crn;
    enc.crm = req_crm;
    enc.op2 = req_op2;
  end

  ctlgate_decode #(
    .OP1_HYP (OP1_HYP),
    .OP1_KERN(OP1_KERN)
  ) u_decode (
    .enc     (enc),
    .hit_hyp (hit_hyp),
    .hit_kern(hit_kern)
  );

  ctlgate_route #(.NV_W(NV_W)) u_route (
    .valid      (req_valid),
    .lvl        (req_lvl),
    .wr         (req_wr),
    .hit_hyp    (hit_hyp),
    .hit_kern   (hit_kern),
    .nest_bits  (nest_bits),
    .hyp_enabled(hyp_enabled),
    .vm_trap_rd (vm_trap_rd),
    .vm_trap_wr (vm_trap_wr),
    .fg_trap_rd (fg_trap_rd),
    .fg_trap_wr (fg_trap_wr),
    .fg_present (fg_present),
    .mon_present(mon_present),
    .mon_fg_en  (mon_fg_en),
    .host_mode  (host_mode),
    .kind       (kind),
    .cause      (cause),
    .tgt        (tgt)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb we[g] = (kind == RSP_ACCESS) && req_wr && (tgt == 1'(g));

    ctlgate_cell #(
      .W   (DATA_W),
      .RST (RSTS[g]),
      .RES0(RES0S[g]),
      .RES1(RES1S[g])
    ) u_cell (
      .clk  (clk),
      .rst  (rst),
      .we   (we[g]),
      .wdata(req_wdata),
      .q    (q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_kind   <= RSP_NONE;
      rsp_cause  <= CAUSE_NONE;
      rsp_class  <= '0;
      rsp_offset <= '0;
      rsp_target <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_kind   <= kind;
      rsp_cause  <= cause;
      rsp_class  <= (kind == RSP_TRAP)  ? TRAP_CLASS : '0;
      rsp_offset <= (kind == RSP_REDIR) ? SHADOW_OFF : '0;
      rsp_target <= (kind == RSP_ACCESS) ? tgt : 1'b0;
      rsp_rdata  <= (kind == RSP_ACCESS && !req_wr) ? q[tgt] : '0;
    end
  end
endmodule

// File: rtl/ctlgate_chk.sv
module ctlgate_chk #(
  parameter int                DATA_W     = 64,
  parameter int                CLS_W      = 6,
  parameter int                OFF_W      = 12,
  parameter int                NV_W       = 3,
  parameter logic [CLS_W-1:0]  TRAP_CLASS = 6'h18,
  parameter logic [OFF_W-1:0]  SHADOW_OFF = 12'h110,
  parameter logic [DATA_W-1:0] HYP_RES0   = '0,
  parameter logic [DATA_W-1:0] HYP_RES1   = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_lvl,
  input logic [1:0]        req_op0,
  input logic [2:0]        req_op1,
  input logic [3:0]        req_crn,
  input logic [3:0]        req_crm,
  input logic [2:0]        req_op2,
  input logic              req_wr,
  input logic [NV_W-1:0]   nest_bits,
  input logic              hyp_enabled,
  input logic              vm_trap_rd,
  input logic [2:0]        rsp_kind,
  input logic [1:0]        rsp_cause,
  input logic [CLS_W-1:0]  rsp_class,
  input logic [OFF_W-1:0]  rsp_offset,
  input logic [DATA_W-1:0] rsp_rdata
);
  logic base_ok, is_hyp, is_kern;
  always_comb begin
    base_ok = (req_op0 == 2'b11) && (req_crn == 4'b0001) &&
              (req_crm == 4'b0000) && (req_op2 == 3'b000);
    is_hyp  = base_ok && (req_op1 == 3'b100);
    is_kern = base_ok && (req_op1 == 3'b000);
  end

  // R2
  a_r2_user_undef: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_lvl == 2'd0 && (is_hyp || is_kern) |=> rsp_kind == 3'd2);

  // R3
  a_r3_hyp_enc_undef: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_lvl == 2'd1 && is_hyp && !nest_bits[0] |=> rsp_kind == 3'd2);

  // R4
  a_r4_vm_read_trap: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_lvl == 2'd1 && is_kern && !req_wr && hyp_enabled && vm_trap_rd
    |=> rsp_kind == 3'd3 && rsp_cause == 2'd2);

  // R5, R3: any trap carries the class code
  a_r5_trap_class: assert property (@(posedge clk) disable iff (rst)
    rsp_kind == 3'd3 |-> rsp_class == TRAP_CLASS);

  // R7
  a_r7_redir_offset: assert property (@(posedge clk) disable iff (rst)
    rsp_kind == 3'd4 |-> rsp_offset == SHADOW_OFF && rsp_class == '0);

  // R10
  a_r10_hyp_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_lvl == 2'd3 && is_hyp && !req_wr
    |=> (rsp_rdata & HYP_RES1) == HYP_RES1 && (rsp_rdata & HYP_RES0) == '0);

  // R11
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> rsp_kind == 3'd0 && rsp_rdata == '0);
endmodule

bind ctlgate_top ctlgate_chk #(
  .DATA_W    (DATA_W),
  .CLS_W     (CLS_W),
  .OFF_W     (OFF_W),
  .NV_W      (NV_W),
  .TRAP_CLASS(TRAP_CLASS),
  .SHADOW_OFF(SHADOW_OFF),
  .HYP_RES0  (HYP_RES0),
  .HYP_RES1  (HYP_RES1)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_lvl    (req_lvl),
  .req_op0    (req_op0),
  .req_op1    (req_op1),
  .req_crn    (req_crn),
  .req_crm    (req_crm),
  .req_op2    (req_op2),
  .req_wr     (req_wr),
  .nest_bits  (nest_bits),
  .hyp_enabled(hyp_enabled),
  .vm_trap_rd (vm_trap_rd),
  .rsp_kind   (rsp_kind),
  .rsp_cause  (rsp_cause),
  .rsp_class  (rsp_class),
  .rsp_offset (rsp_offset),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/tb_ctlgate_top.sv
module tb_ctlgate_top;
  localparam logic [63:0] H_RST  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] H_RES0 = 64'hFF00_0000_0000_0000;
  localparam logic [63:0] H_RES1 = 64'h0000_0000_30C5_0830;
  localparam logic [63:0] K_RST  = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] K_RES0 = 64'hF000_0000_0000_0000;
  localparam logic [63:0] K_RES1 = 64'h0000_0000_0080_0800;

  localparam int K_NONE = 0, K_ACC = 1, K_UND = 2, K_TRAP = 3, K_RED = 4;
  localparam int C_NONE = 0, C_NEST = 1, C_VM = 2, C_FG = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_lvl = '0;
  logic [1:0] req_op0 = '0;
  logic [2:0] req_op1 = '0;
  logic [3:0] req_crn = '0;
  logic [3:0] req_crm = '0;
  logic [2:0] req_op2 = '0;
  logic req_wr = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [2:0] nest_bits = '0;
  logic hyp_enabled = 1'b0, vm_trap_rd = 1'b0, vm_trap_wr = 1'b0;
  logic fg_trap_rd = 1'b0, fg_trap_wr = 1'b0, fg_present = 1'b0;
  logic mon_present = 1'b0, mon_fg_en = 1'b0, host_mode = 1'b0;
  logic [2:0]  rsp_kind;
  logic [1:0]  rsp_cause;
  logic [5:0]  rsp_class;
  logic [11:0] rsp_offset;
  logic        rsp_target;
  logic [63:0] rsp_rdata;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [63:0] m_hyp, m_kern;

  always #10 clk = ~clk;

  ctlgate_top #(
    .HYP_RST(H_RST), .HYP_RES0(H_RES0), .HYP_RES1(H_RES1),
    .KERN_RST(K_RST), .KERN_RES0(K_RES0), .KERN_RES1(K_RES1)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lvl(req_lvl),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_wr(req_wr), .req_wdata(req_wdata),
    .nest_bits(nest_bits), .hyp_enabled(hyp_enabled),
    .vm_trap_rd(vm_trap_rd), .vm_trap_wr(vm_trap_wr),
    .fg_trap_rd(fg_trap_rd), .fg_trap_wr(fg_trap_wr), .fg_present(fg_present),
    .mon_present(mon_present), .mon_fg_en(mon_fg_en), .host_mode(host_mode),
    .rsp_kind(rsp_kind), .rsp_cause(rsp_cause), .rsp_class(rsp_class),
    .rsp_offset(rsp_offset), .rsp_target(rsp_target), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [63:0] fixv(logic [63:0] v, logic [63:0] r0, logic [63:0] r1);
    return (v & ~r0) | r1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic clear_ctl();
    nest_bits = '0; hyp_enabled = 0; vm_trap_rd = 0; vm_trap_wr = 0;
    fg_trap_rd = 0; fg_trap_wr = 0; fg_present = 0; mon_present = 0;
    mon_fg_en = 0; host_mode = 0;
  endtask

  // enc: 0 kernel encoding, 1 hypervisor encoding, 2 unmatched
  task automatic drive(input int lvl, input int enc, input bit wr, input logic [63:0] wd);
    @(negedge clk);
    req_lvl = 2'(lvl);
    req_op0 = 2'b11; req_crn = 4'b0001; req_crm = 4'b0000; req_op2 = 3'b000;
    req_op1 = (enc == 1) ? 3'b100 : (enc == 0) ? 3'b000 : 3'b010;
    req_wr = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_wr = 1'b0;
  endtask

  task automatic check(input string rq, input int kind, input int cause,
                       input int tgt, input bit chk_rd, input logic [63:0] rd);
    logic [5:0]  ecls;
    logic [11:0] eoff;
    logic [63:0] erd;
    ecls = (kind == K_TRAP) ? 6'h18 : 6'h00;
    eoff = (kind == K_RED) ? 12'h110 : 12'h000;
    erd  = chk_rd ? rd : 64'h0;
    n_vec++;
    if (rsp_kind !== 3'(kind) || rsp_cause !== 2'(cause) || rsp_class !== ecls ||
        rsp_offset !== eoff || rsp_target !== 1'(tgt) || rsp_rdata !== erd) begin
      n_bad++;
      $display("FAIL %s: act kind=%0d cause=%0d cls=%h off=%h tgt=%0d rd=%h exp kind=%0d cause=%0d cls=%h off=%h tgt=%0d rd=%h",
               rq, rsp_kind, rsp_cause, rsp_class, rsp_offset, rsp_target, rsp_rdata,
               kind, cause, ecls, eoff, tgt, erd);
    end
  endtask

  task automatic peek(input string rq, input int enc);
    drive(3, enc, 1'b0, '0);
    check(rq, K_ACC, C_NONE, enc, 1'b1, enc == 1 ? m_hyp : m_kern);
  endtask

  task automatic t_reset();
    check("R1 idle", K_NONE, C_NONE, 0, 1'b0, '0);
    peek("R1 hyp reset", 1);
    peek("R1 kern reset", 0);
  endtask

  task automatic t_user();
    drive(0, 1, 1'b0, '0);               check("R2 user rd hyp", K_UND, C_NONE, 0, 0, '0);
    drive(0, 0, 1'b1, 64'hDEAD_BEEF);    check("R2 user wr kern", K_UND, C_NONE, 0, 0, '0);
    peek("R2 kern unchanged", 0);
  endtask

  task automatic t_kern_hyp();
    nest_bits = 3'b000;
    drive(1, 1, 1'b0, '0);               check("R3 undef", K_UND, C_NONE, 0, 0, '0);
    nest_bits = 3'b001;
    drive(1, 1, 1'b1, 64'h55);           check("R3 nested trap", K_TRAP, C_NEST, 0, 0, '0);
    clear_ctl();
    peek("R3 hyp unchanged", 1);
  endtask

  task automatic t_vm();
    hyp_enabled = 1; vm_trap_rd = 1;
    drive(1, 0, 1'b0, '0);               check("R4 rd trap", K_TRAP, C_VM, 0, 0, '0);
    drive(1, 0, 1'b1, 64'h1234_5678);    check("R4 wr ignores rd bit", K_ACC, C_NONE, 0, 0, '0);
    m_kern = fixv(64'h1234_5678, K_RES0, K_RES1);
    vm_trap_rd = 0; vm_trap_wr = 1;
    drive(1, 0, 1'b1, 64'hAAAA_0000);    check("R4 wr trap", K_TRAP, C_VM, 0, 0, '0);
    drive(1, 0, 1'b0, '0);               check("R4 rd ignores wr bit", K_ACC, C_NONE, 0, 1, m_kern);
    hyp_enabled = 0; vm_trap_rd = 1;
    drive(1, 0, 1'b0, '0);               check("R4 hyp disabled", K_ACC, C_NONE, 0, 1, m_kern);
    clear_ctl();
    peek("R4 trapped write dropped", 0);
  endtask

  task automatic t_fg();
    fg_trap_rd = 1; fg_present = 1; mon_present = 0;
    drive(1, 0, 1'b0, '0);               check("R5 no monitor", K_TRAP, C_FG, 0, 0, '0);
    mon_present = 1; mon_fg_en = 0;
    drive(1, 0, 1'b0, '0);               check("R5 monitor disables", K_ACC, C_NONE, 0, 1, m_kern);
    mon_fg_en = 1;
    drive(1, 0, 1'b0, '0);               check("R5 monitor enables", K_TRAP, C_FG, 0, 0, '0);
    fg_present = 0;
    drive(1, 0, 1'b0, '0);               check("R5 feature absent", K_ACC, C_NONE, 0, 1, m_kern);
    fg_present = 1; fg_trap_rd = 0; fg_trap_wr = 1;
    drive(1, 0, 1'b1, 64'h9);            check("R5 write trap", K_TRAP, C_FG, 0, 0, '0);
    clear_ctl();
  endtask

  task automatic t_prio();
    hyp_enabled = 1; vm_trap_rd = 1; fg_trap_rd = 1; fg_present = 1; nest_bits = 3'b111;
    drive(1, 0, 1'b0, '0);               check("R6 vm first", K_TRAP, C_VM, 0, 0, '0);
    vm_trap_rd = 0;
    drive(1, 0, 1'b0, '0);               check("R6 fg before nest", K_TRAP, C_FG, 0, 0, '0);
    fg_trap_rd = 0;
    drive(1, 0, 1'b1, 64'hFEED);         check("R7 redirect", K_RED, C_NONE, 0, 0, '0);
    nest_bits = 3'b011;
    drive(1, 0, 1'b0, '0);               check("R7 partial nest", K_ACC, C_NONE, 0, 1, m_kern);
    clear_ctl();
    peek("R7 no write", 0);
    peek("R7 hyp untouched", 1);
  endtask

  task automatic t_hyp_lvl();
    host_mode = 0;
    drive(2, 0, 1'b1, 64'h0000_0000_0000_00F0); check("R8 kern via hyp", K_ACC, C_NONE, 0, 0, '0);
    m_kern = fixv(64'hF0, K_RES0, K_RES1);
    host_mode = 1;
    drive(2, 0, 1'b1, 64'h0000_0000_0000_0F00); check("R8 host redirect", K_ACC, C_NONE, 1, 0, '0);
    m_hyp = fixv(64'hF00, H_RES0, H_RES1);
    drive(2, 1, 1'b0, '0);               check("R8 hyp enc", K_ACC, C_NONE, 1, 1, m_hyp);
    clear_ctl();
    peek("R8 kern value", 0);
    peek("R8 hyp value", 1);
    nest_bits = 3'b111; hyp_enabled = 1; vm_trap_wr = 1; vm_trap_rd = 1;
    drive(3, 0, 1'b1, 64'h0707);         check("R9 monitor kern", K_ACC, C_NONE, 0, 0, '0);
    m_kern = fixv(64'h0707, K_RES0, K_RES1);
    drive(3, 1, 1'b0, '0);               check("R9 monitor hyp", K_ACC, C_NONE, 1, 1, m_hyp);
    clear_ctl();
    peek("R9 kern stored", 0);
  endtask

  task automatic t_mask();
    drive(3, 1, 1'b1, '1);               check("R10 wr ones", K_ACC, C_NONE, 1, 0, '0);
    m_hyp = fixv('1, H_RES0, H_RES1);
    peek("R12 R10 hyp ones", 1);
    drive(3, 0, 1'b1, '0);               check("R10 wr zeros", K_ACC, C_NONE, 0, 0, '0);
    m_kern = fixv('0, K_RES0, K_RES1);
    peek("R12 R10 kern zeros", 0);
  endtask

  task automatic t_nomatch();
    drive(3, 2, 1'b1, 64'h1111);         check("R11 unmatched", K_NONE, C_NONE, 0, 0, '0);
    @(negedge clk);
    req_lvl = 2'd3; req_op1 = 3'b100; req_wr = 1'b1; req_wdata = 64'h2222; req_valid = 1'b0;
    @(negedge clk);
    req_wr = 1'b0;
    check("R11 no valid", K_NONE, C_NONE, 0, 0, '0);
    peek("R11 hyp kept", 1);
    peek("R11 kern kept", 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act timeout exp completion");
    finish_run();
  end

  initial begin
    m_hyp  = fixv(H_RST, H_RES0, H_RES1);
    m_kern = fixv(K_RST, K_RES0, K_RES1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_user();
    t_kern_hyp();
    t_vm();
    t_fg();
    t_prio();
    t_hyp_lvl();
    t_mask();
    t_nomatch();
    finish_run();
  end
endmodule